// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block supervises running software with a watchdog that counts instruction-cycle ticks. Software proves it is alive by writing one service byte. That byte carries a fixed secret key, a window-size code and a clock-monitor enable flag. Each write is judged against the stored settings and against how many ticks have passed since the current window opened. An accepted service starts a fresh window. A wrong key, a field that differs from the stored settings, a service that arrives too early, or silence until the window runs out each raise a one-cycle error pulse. After an error the window starts over.

The first accepted service after reset sets the window size and the monitor flag, and they are then locked until the next reset. Until that happens the longest window is in force and no lower bound applies. Two inhibit inputs suspend checking. During halt the count is frozen and resumes where it stopped. Leaving idle counts as an automatic service, so a fresh window begins. The interface is a plain write strobe with data and a combinational readback. There is no streaming path, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the window code is 11, the clock-monitor enable is 1, the readback is 8'hC1 and the error output is low.
- R2: The service byte holds the window code in bits [7:6], the key in bits [5:1] and the monitor enable in bit [0]. The key is 5'b01100. Readback returns the stored code and flag, with zeros in bits [5:1].
- R3: Before the configuration is locked, a write whose key matches is accepted at any count, including zero. It stores the code and flag from the byte. A write with any other key raises an error and leaves the configuration unlocked.
- R4: Once locked, the window code and monitor flag never change until reset, whatever is written.
- R5: After locking, a service is rejected with an error unless its key, window code and monitor flag all equal the stored values.
- R6: After locking, a service seen when fewer than MIN_TICKS ticks have passed in the current window raises an error. A service seen at exactly MIN_TICKS ticks is accepted.
- R7: Window codes 0, 1, 2 and 3 give limits of BASE_WINDOW times 1, 2, 4 and 8 ticks. The error fires on the tick that brings the count to the limit.
- R8: Every error is a single clock cycle high and restarts the window from zero. The next timeout therefore comes a full window later.
- R9: An accepted service restarts the window from zero.
- R10: While halt_i is high, ticks do not advance the count, writes are ignored and no error is raised. Counting resumes from the held value.
- R11: While idle_i is high, checking is suspended in the same way. On the cycle idle_i falls, the count is cleared as an automatic service.
- R12: The count advances only on clock cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle tick enable |
| idle_i | input | 1 | Idle inhibit; its falling edge acts as an automatic service |
| halt_i | input | 1 | Halt inhibit; the count is held |
| wr_en_i | input | 1 | Service-register write strobe |
| wr_data_i | input | 8 | Service byte |
| rd_data_o | output | 8 | Readback with the key field masked |
| mon_en_o | output | 1 | Stored clock-monitor enable |
| wdog_err_o | output | 1 | One-cycle watchdog error pulse |

## Verification
The bench uses a small configuration with MIN_TICKS of 4 and BASE_WINDOW of 16. For every window code it measures the number of ticks to timeout, which separates the four limits and shows that an error restarts the window. A sweep of service delays from 0 to 6 ticks locates the exact lower bound. Writes that each corrupt only one field (code, flag or key) show that every field is compared on its own. Runs with halt, idle and a held-low tick compare a frozen count against a cleared one and show that writes are ignored while inhibited.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0] WDT_KEY = 5'b01100;

  typedef struct packed {
    logic [1:0] sel;
    logic [4:0] key;
    logic       mon;
  } svc_byte_t;

  typedef struct packed {
    logic       locked;
    logic [1:0] sel;
    logic       mon;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step     = run_i & tick_i;
  assign expire_o = step & (cnt_q == limit_i - CW'(1));
  assign count_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i || expire_o) cnt_q <= '0;
    else if (step)              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/wdt_svc_judge.sv
module wdt_svc_judge
  import wdt_pkg::*;
#(
  parameter int CW        = 17,
  parameter int MIN_TICKS = 2048
) (
  input  logic          wr_act_i,
  input  svc_byte_t     svc_i,
  input  wdt_cfg_t      cfg_i,
  input  logic [CW-1:0] count_i,
  output logic          accept_o,
  output logic          reject_o
);
  logic key_ok, fields_ok, late_enough, ok;

  always_comb begin
    key_ok      = (svc_i.key == WDT_KEY);
    fields_ok   = (svc_i.sel == cfg_i.sel) && (svc_i.mon == cfg_i.mon);
    late_enough = (count_i >= CW'(MIN_TICKS));
    if (cfg_i.locked) ok = key_ok && fields_ok && late_enough;
    else              ok = key_ok;
    accept_o = wr_act_i & ok;
    reject_o = wr_act_i & ~ok;
  end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int MIN_TICKS   = 2048,
  parameter int BASE_WINDOW = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       idle_i,
  input  logic       halt_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       mon_en_o,
  output logic       wdog_err_o
);
  localparam int CW = $clog2(BASE_WINDOW) + 4;
  localparam wdt_cfg_t CFG_RST = '{locked: 1'b0, sel: 2'b11, mon: 1'b1};

  wdt_cfg_t      cfg_q;
  svc_byte_t     svc;
  logic          run, wr_act, idle_q, idle_fall;
  logic          accept, reject, expire, clr, err_q;
  logic [CW-1:0] count, limit;

  assign svc       = svc_byte_t'(wr_data_i);
  assign run       = ~idle_i & ~halt_i;
  assign wr_act    = wr_en_i & run;
  assign idle_fall = idle_q & ~idle_i;
  assign limit     = CW'(BASE_WINDOW) << cfg_q.sel;
  assign clr       = accept | reject | idle_fall;

  wdt_tick_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (run),
    .clr_i   (clr),
    .limit_i (limit),
    .count_o (count),
    .expire_o(expire)
  );

  wdt_svc_judge #(.CW(CW), .MIN_TICKS(MIN_TICKS)) u_judge (
    .wr_act_i(wr_act),
    .svc_i   (svc),
    .cfg_i   (cfg_q),
    .count_i (count),
    .accept_o(accept),
    .reject_o(reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      idle_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      idle_q <= idle_i;
      err_q  <= reject | (expire & ~wr_act & ~idle_fall);
      if (accept && !cfg_q.locked)
        cfg_q <= '{locked: 1'b1, sel: svc.sel, mon: svc.mon};
    end
  end

  assign rd_data_o  = {cfg_q.sel, 5'b00000, cfg_q.mon};
  assign mon_en_o   = cfg_q.mon;
  assign wdog_err_o = err_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_i,
  input logic          halt_i,
  input logic          err,
  input logic          locked,
  input logic [1:0]    sel,
  input logic          mon,
  input logic [CW-1:0] count,
  input logic [CW-1:0] limit,
  input logic          idle_fall
);
  assert_prelock_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (sel == 2'b11 && mon));

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(sel) && $stable(mon) && locked));

  assert_cnt_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count < limit);

  assert_err_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> count == '0);

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !idle_fall) |=> ($stable(count) && !err));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> ($stable(count) && !err));
endmodule

bind wdt_keyed_top wdt_keyed_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idle_i   (idle_i),
  .halt_i   (halt_i),
  .err      (wdog_err_o),
  .locked   (cfg_q.locked),
  .sel      (cfg_q.sel),
  .mon      (cfg_q.mon),
  .count    (count),
  .limit    (limit),
  .idle_fall(idle_fall)
);

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb;
  localparam int MINT = 4;
  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       idle_i = 1'b0;
  logic       halt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       mon_en_o;
  logic       wdog_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int n;

  always #4 clk = ~clk;

  wdt_keyed_top #(.MIN_TICKS(MINT), .BASE_WINDOW(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i),
    .halt_i(halt_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .mon_en_o(mon_en_o), .wdog_err_o(wdog_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] s, input logic m);
    return {s, 5'b01100, m};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_en_i = 1'b0; idle_i = 1'b0; halt_i = 1'b0; tick_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic to_err(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!wdog_err_o && cnt < 2000);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 readback", rd_data_o, 8'hC1);
    chk("R1 err", wdog_err_o, 0);
    chk("R1 mon", mon_en_o, 1);

    to_err(n);
    chk("R7 prelock timeout", n, BASE * 8);
    @(negedge clk);
    chk("R8 single pulse", wdog_err_o, 0);
    to_err(n);
    chk("R8 restart after error", n, BASE * 8 - 1);

    wr(8'h00);
    chk("R3 bad key err", wdog_err_o, 1);
    chk("R3 unlocked", rd_data_o, 8'hC1);
    wr(mk(2'b00, 1'b0));
    chk("R3 first svc early ok", wdog_err_o, 0);
    chk("R2 key masked", rd_data_o, 8'h00);

    for (int d = 0; d <= 6; d++) begin
      repeat (d) @(negedge clk);
      wr(mk(2'b00, 1'b0));
      chk($sformatf("R6 R9 delay %0d", d), wdog_err_o, (d < MINT) ? 1 : 0);
    end

    repeat (6) @(negedge clk);
    wr(mk(2'b01, 1'b0));
    chk("R5 sel mismatch", wdog_err_o, 1);
    repeat (6) @(negedge clk);
    wr(mk(2'b00, 1'b1));
    chk("R5 mon mismatch", wdog_err_o, 1);
    repeat (6) @(negedge clk);
    wr({2'b00, 5'b01101, 1'b0});
    chk("R5 key mismatch", wdog_err_o, 1);
    chk("R4 config locked", rd_data_o, 8'h00);
    repeat (6) @(negedge clk);
    wr(mk(2'b00, 1'b0));
    chk("R5 good svc", wdog_err_o, 0);
    to_err(n);
    chk("R9 R7 timeout code0", n, BASE);

    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(mk(s[1:0], 1'b1));
      chk($sformatf("R2 readback code %0d", s), rd_data_o, {s[1:0], 5'b0, 1'b1});
      to_err(n);
      chk($sformatf("R7 limit code %0d", s), n, BASE << s);
    end

    do_reset();
    wr(mk(2'b01, 1'b1));
    repeat (5) @(negedge clk);
    halt_i = 1'b1;
    repeat (10) @(negedge clk);
    wr(8'h00);
    chk("R10 write ignored", wdog_err_o, 0);
    repeat (10) @(negedge clk);
    halt_i = 1'b0;
    to_err(n);
    chk("R10 resume count", n, 2 * BASE - 5);
    chk("R10 cfg kept", rd_data_o, 8'h41);

    repeat (6) @(negedge clk);
    wr(mk(2'b01, 1'b1));
    chk("R9 svc ok", wdog_err_o, 0);
    repeat (10) @(negedge clk);
    idle_i = 1'b1;
    repeat (10) @(negedge clk);
    wr(8'h00);
    chk("R11 write ignored", wdog_err_o, 0);
    repeat (10) @(negedge clk);
    idle_i = 1'b0;
    to_err(n);
    chk("R11 idle exit restart", n, 2 * BASE + 1);

    repeat (6) @(negedge clk);
    wr(mk(2'b01, 1'b1));
    tick_i = 1'b0;
    repeat (50) @(negedge clk);
    chk("R12 no tick no err", wdog_err_o, 0);
    tick_i = 1'b1;
    to_err(n);
    chk("R12 tick gated count", n, 2 * BASE);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule